// File: doc/BRIEF.md
# Dual-Discipline Multiplexed Host Bus Interface

This block connects a timekeeping peripheral to a host over a shared 8-bit address/data bus. One static mode input selects the strobe discipline. In enable/direction mode, a data strobe frames the transfer and a read/write level gives the direction. In split-strobe mode, the same two pins serve as separate active-low read and write strobes. Every bus pin is brought into the system clock domain through a synchronizer. All edges are found on the synchronized copies.

An access has two phases. In the address phase, the falling edge of the address strobe captures the byte on the bus and a bank-select bit. In the data phase, an active-low chip select must stay low while the block either drives read data or captures write data. The captured address is decoded into one of four regions: the 14 clock/control bytes, the 242 general storage bytes, a 128-byte extended bank, or unmapped space. Each access reaches the back end as a one-cycle strobe that carries a region code and an index.

The controller has four states:
- `ST_IDLE`: no address held.
- `ST_ADDR`: address held, waiting for a data phase.
- `ST_READ`: driving the bus.
- `ST_WRITE`: waiting for the write-closing edge.

It has these transitions:
- `latch`: any state to `ST_ADDR` on an address-strobe fall.
- `open_rd`: `ST_ADDR` to `ST_READ`.
- `open_wr`: `ST_ADDR` to `ST_WRITE`.
- `close_rd`: `ST_READ` to `ST_IDLE` at the end of the read strobe.
- `commit`: `ST_WRITE` to `ST_IDLE`, with the write pulse.
- `abort`: `ST_READ` or `ST_WRITE` to `ST_IDLE` when chip select goes high.

Top module: `rtc_hostbus_if`

## Requirements
- R1: A falling edge of `as_i` captures `ad_i` and `xram_i` as the access address, whether or not `cs_n_i` is low at that moment.
- R2: In enable/direction mode (mode captured as 1), a rising `ds_i` while `rw_i` is high starts a read. `ad_oe_o` is then high, with the addressed byte on `ad_o`, until `ds_i` falls.
- R3: In enable/direction mode, a rising `ds_i` while `rw_i` is low opens a write. The byte present on `ad_i` when `ds_i` falls is written.
- R4: In split-strobe mode (mode captured as 0), `ds_i` low acts as a read strobe. `ad_oe_o` is high with the addressed byte from the falling edge of `ds_i` until it rises again.
- R5: In split-strobe mode, `rw_i` low acts as a write strobe. The byte on `ad_i` at its rising edge is written.
- R6: If `cs_n_i` is high when a data phase would open, or goes high at any point before it closes, no write pulse is issued and `ad_oe_o` stays or returns low.
- R7: With `xram_i` low, address 0 to 13 maps to region code 0 (clock/control) with index equal to the address. Address 14 to 255 maps to region code 1 (storage) with index equal to the address minus 14.
- R8: With `xram_i` high, address 0 to 127 maps to region code 2 (extended bank) with index equal to the address. Address 128 to 255 is region code 3 (unmapped): writes cause no pulse, and reads issue no back-end read but drive 0xFF.
- R9: While `rst_n` is low, no access is accepted: no back-end pulse and `ad_oe_o` low.
- R10: `mode_moto_i` is taken only while `rst_n` is low. Later changes have no effect.
- R11: `ad_oe_o` is low outside read windows, and its value is steady while high. After a read or write completes, a further data strobe without a new address-strobe fall does nothing.
- R12: `acc_rd_o` and `acc_wr_o` each last exactly one clock, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all bus pins |
| rst_n | input | 1 | Active-low synchronous reset; captures the mode |
| mode_moto_i | input | 1 | 1 = enable/direction discipline, 0 = split-strobe discipline |
| as_i | input | 1 | Address strobe; falling edge captures the address |
| ds_i | input | 1 | Data strobe (enable) or active-low read strobe |
| rw_i | input | 1 | Direction level or active-low write strobe |
| cs_n_i | input | 1 | Active-low chip select for the data phase |
| xram_i | input | 1 | Bank select captured with the address |
| ad_i | input | 8 | Bus value seen by the block |
| ad_o | output | 8 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Bus drive enable |
| acc_rd_o | output | 1 | One-cycle back-end read request |
| acc_wr_o | output | 1 | One-cycle back-end write request |
| acc_rgn_o | output | 2 | Decoded region code (0 ctrl, 1 storage, 2 ext bank, 3 none) |
| acc_idx_o | output | 8 | Byte index within the region |
| acc_wdata_o | output | 8 | Write data for the back end |
| acc_rdata_i | input | 8 | Back-end read data for the current region and index |

## Verification
The hardest situation to reach is chip select being withdrawn after a data phase has opened but before its closing edge. From the port list it looks like an ordinary write. The bench holds the data strobe high, raises chip select for several cycles, and only then lets the strobe fall. It then confirms from the write-pulse count and the back-end model that nothing changed. A similar trap is a second data strobe after a completed write with no fresh address strobe; the bench issues one on purpose and expects silence.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        RGN_CTRL  = 2'd0,
        RGN_STORE = 2'd1,
        RGN_XBANK = 2'd2,
        RGN_NONE  = 2'd3
    } rgn_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_WRITE
    } bus_st_e;

    // bus pins as seen after synchronization
    typedef struct packed {
        logic             as_l;
        logic             ds_l;
        logic             rw_l;
        logic             cs_n;
        logic             xram;
        logic [BUS_W-1:0] ad;
    } pins_t;

endpackage

// File: rtl/rtc_bus_sync.sv
module rtc_bus_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        pipe[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_bus_pkg::*;
#(
    parameter int CTRL_BYTES  = 14,
    parameter int XBANK_BYTES = 128
) (
    input  logic [BUS_W-1:0] addr_i,
    input  logic             xram_i,
    output rgn_e             rgn_o,
    output logic [BUS_W-1:0] idx_o,
    output logic             mapped_o
);
    localparam logic [BUS_W-1:0] CTRL_LIM  = BUS_W'(CTRL_BYTES);
    localparam logic [BUS_W:0]   XBANK_LIM = (BUS_W+1)'(XBANK_BYTES);

    rgn_e             base_rgn;
    logic [BUS_W-1:0] base_idx;
    rgn_e             ext_rgn;

    always_comb begin
        if (addr_i < CTRL_LIM) begin
            base_rgn = RGN_CTRL;
            base_idx = addr_i;
        end else begin
            base_rgn = RGN_STORE;
            base_idx = addr_i - CTRL_LIM;
        end
    end

    generate
        if (XBANK_BYTES > 0) begin : g_xbank
            assign ext_rgn = ({1'b0, addr_i} < XBANK_LIM) ? RGN_XBANK : RGN_NONE;
        end else begin : g_no_xbank
            assign ext_rgn = RGN_NONE;
        end
    endgenerate

    always_comb begin
        rgn_o    = xram_i ? ext_rgn : base_rgn;
        idx_o    = xram_i ? addr_i  : base_idx;
        mapped_o = (rgn_o != RGN_NONE);
    end
endmodule

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_bus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  pins_t            pin_s,
    input  logic             mapped_i,
    input  logic [BUS_W-1:0] acc_rdata_i,
    output logic [BUS_W-1:0] addr_q_o,
    output logic             xram_q_o,
    output logic             acc_rd_o,
    output logic             acc_wr_o,
    output logic [BUS_W-1:0] acc_wdata_o,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe_o
);
    bus_st_e          st_q, st_d;
    logic             moto_q;
    logic             as_p, ds_p, rw_p;
    logic [BUS_W-1:0] rdata_q;

    logic as_fall, ds_rise, ds_fall, rw_rise, rw_fall, cs_ok;
    logic rd_go, wr_go;

    // edges on the synchronized strobes
    always_comb begin
        as_fall = as_p & ~pin_s.as_l;
        ds_rise = ~ds_p & pin_s.ds_l;
        ds_fall = ds_p & ~pin_s.ds_l;
        rw_rise = ~rw_p & pin_s.rw_l;
        rw_fall = rw_p & ~pin_s.rw_l;
        cs_ok   = ~pin_s.cs_n;
    end

    // next state and transfer requests
    always_comb begin
        st_d  = st_q;
        rd_go = 1'b0;
        wr_go = 1'b0;
        if (as_fall) begin
            st_d = ST_ADDR;                              // latch
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_ADDR: begin
                    if (moto_q) begin
                        if (ds_rise && cs_ok) begin
                            if (pin_s.rw_l) begin
                                st_d  = ST_READ;         // open_rd
                                rd_go = 1'b1;
                            end else begin
                                st_d = ST_WRITE;         // open_wr
                            end
                        end
                    end else begin
                        if (ds_fall && cs_ok) begin
                            st_d  = ST_READ;             // open_rd
                            rd_go = 1'b1;
                        end else if (rw_fall && cs_ok) begin
                            st_d = ST_WRITE;             // open_wr
                        end
                    end
                end
                ST_READ: begin
                    if (!cs_ok) begin
                        st_d = ST_IDLE;                  // abort
                    end else if (moto_q ? ds_fall : ds_rise) begin
                        st_d = ST_IDLE;                  // close_rd
                    end
                end
                ST_WRITE: begin
                    if (!cs_ok) begin
                        st_d = ST_IDLE;                  // abort
                    end else if (moto_q ? ds_fall : rw_rise) begin
                        st_d  = ST_IDLE;                 // commit
                        wr_go = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // mode capture, strobe history, address and read-data holding
    always_ff @(posedge clk) begin
        as_p <= pin_s.as_l;
        ds_p <= pin_s.ds_l;
        rw_p <= pin_s.rw_l;
        if (!rst_n) begin
            moto_q   <= mode_i;
            addr_q_o <= '0;
            xram_q_o <= 1'b0;
            rdata_q  <= '1;
        end else begin
            if (as_fall) begin
                addr_q_o <= pin_s.ad;
                xram_q_o <= pin_s.xram;
            end
            if (rd_go) begin
                rdata_q <= mapped_i ? acc_rdata_i : '1;
            end
        end
    end

    // outputs
    always_comb begin
        acc_rd_o    = rd_go & mapped_i;
        acc_wr_o    = wr_go & mapped_i;
        acc_wdata_o = pin_s.ad;
        ad_oe_o     = (st_q == ST_READ);
        ad_o        = rdata_q;
    end
endmodule

// File: rtl/rtc_hostbus_if.sv
module rtc_hostbus_if
    import rtc_bus_pkg::*;
#(
    parameter int CTRL_BYTES  = 14,
    parameter int XBANK_BYTES = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_moto_i,
    input  logic             as_i,
    input  logic             ds_i,
    input  logic             rw_i,
    input  logic             cs_n_i,
    input  logic             xram_i,
    input  logic [BUS_W-1:0] ad_i,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe_o,
    output logic             acc_rd_o,
    output logic             acc_wr_o,
    output logic [1:0]       acc_rgn_o,
    output logic [BUS_W-1:0] acc_idx_o,
    output logic [BUS_W-1:0] acc_wdata_o,
    input  logic [BUS_W-1:0] acc_rdata_i
);
    localparam int PIN_W = $bits(pins_t);

    logic [PIN_W-1:0] raw_pins, sync_pins;
    pins_t            pin_s;
    logic [BUS_W-1:0] addr_q;
    logic             xram_q;
    rgn_e             rgn;
    logic             mapped;

    assign raw_pins = {as_i, ds_i, rw_i, cs_n_i, xram_i, ad_i};

    rtc_bus_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    assign pin_s = pins_t'(sync_pins);

    rtc_bus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_moto_i),
        .pin_s       (pin_s),
        .mapped_i    (mapped),
        .acc_rdata_i (acc_rdata_i),
        .addr_q_o    (addr_q),
        .xram_q_o    (xram_q),
        .acc_rd_o    (acc_rd_o),
        .acc_wr_o    (acc_wr_o),
        .acc_wdata_o (acc_wdata_o),
        .ad_o        (ad_o),
        .ad_oe_o     (ad_oe_o)
    );

    rtc_bus_decode #(.CTRL_BYTES(CTRL_BYTES), .XBANK_BYTES(XBANK_BYTES)) u_dec (
        .addr_i   (addr_q),
        .xram_i   (xram_q),
        .rgn_o    (rgn),
        .idx_o    (acc_idx_o),
        .mapped_o (mapped)
    );

    assign acc_rgn_o = rgn;
endmodule

// File: rtl/rtc_hostbus_if_chk.sv
module rtc_hostbus_if_chk #(
    parameter int CTRL_BYTES = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_rd_o,
    input logic       acc_wr_o,
    input logic [1:0] acc_rgn_o,
    input logic [7:0] acc_idx_o,
    input logic [7:0] ad_o,
    input logic       ad_oe_o
);
    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_rd_o, acc_wr_o}));

    assert_wr_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_o |=> !acc_wr_o);

    assert_rd_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd_o |=> !acc_rd_o);

    assert_rd_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd_o |=> ad_oe_o);

    assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_o |-> !ad_oe_o);

    assert_drive_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe_o && $past(ad_oe_o)) |-> $stable(ad_o));

    assert_strobe_mapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd_o || acc_wr_o) |-> (acc_rgn_o != 2'd3));

    assert_ctrl_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd_o || acc_wr_o) && acc_rgn_o == 2'd0) |-> (acc_idx_o < 8'(CTRL_BYTES)));

    assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ad_oe_o && !acc_wr_o && !acc_rd_o));
endmodule

bind rtc_hostbus_if rtc_hostbus_if_chk #(.CTRL_BYTES(CTRL_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd_o  (acc_rd_o),
    .acc_wr_o  (acc_wr_o),
    .acc_rgn_o (acc_rgn_o),
    .acc_idx_o (acc_idx_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o)
);

// File: tb/rtc_hostbus_if_tb.sv
module rtc_hostbus_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b1;
    logic       ale = 1'b0, dstb = 1'b0, rwb = 1'b1, csn = 1'b1, xram = 1'b0;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_o, acc_idx_o, acc_wdata_o, acc_rdata_i;
    logic       ad_oe_o, acc_rd_o, acc_wr_o;
    logic [1:0] acc_rgn_o;

    int n_checks = 0, n_fail = 0;
    int wr_pulses = 0, rd_pulses = 0;
    int wr_run = 0, rd_run = 0, wr_run_max = 0, rd_run_max = 0;
    bit finished = 0;

    logic [7:0] m_ctrl  [14];
    logic [7:0] m_store [242];
    logic [7:0] m_xb    [128];

    always #4 clk = ~clk;

    rtc_hostbus_if u_dut (
        .clk(clk), .rst_n(rst_n), .mode_moto_i(mode),
        .as_i(ale), .ds_i(dstb), .rw_i(rwb), .cs_n_i(csn), .xram_i(xram),
        .ad_i(ad_in), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
        .acc_rd_o(acc_rd_o), .acc_wr_o(acc_wr_o), .acc_rgn_o(acc_rgn_o),
        .acc_idx_o(acc_idx_o), .acc_wdata_o(acc_wdata_o), .acc_rdata_i(acc_rdata_i)
    );

    // back-end model
    always @(posedge clk) begin
        if (acc_wr_o) begin
            case (acc_rgn_o)
                2'd0: m_ctrl[acc_idx_o]  <= acc_wdata_o;
                2'd1: m_store[acc_idx_o] <= acc_wdata_o;
                2'd2: m_xb[acc_idx_o]    <= acc_wdata_o;
                default: ;
            endcase
        end
        if (acc_wr_o) begin wr_pulses++; wr_run++; end else wr_run = 0;
        if (acc_rd_o) begin rd_pulses++; rd_run++; end else rd_run = 0;
        if (wr_run > wr_run_max) wr_run_max = wr_run;
        if (rd_run > rd_run_max) rd_run_max = rd_run;
    end

    always_comb begin
        case (acc_rgn_o)
            2'd0:    acc_rdata_i = m_ctrl[acc_idx_o];
            2'd1:    acc_rdata_i = m_store[acc_idx_o];
            2'd2:    acc_rdata_i = m_xb[acc_idx_o];
            default: acc_rdata_i = 8'h00;
        endcase
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w4();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0;
        mode  = m;
        ale   = 1'b0;
        dstb  = m ? 1'b0 : 1'b1;
        rwb   = 1'b1;
        csn   = 1'b1;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        w4();
    endtask

    task automatic addr_phase(input logic [7:0] a, input logic x);
        ad_in = a; xram = x; w4();
        ale = 1'b1; w4();
        ale = 1'b0; w4();
    endtask

    task automatic moto_write(input logic [7:0] a, input logic x, input logic [7:0] d);
        addr_phase(a, x);
        csn = 1'b0; rwb = 1'b0; ad_in = d; w4();
        dstb = 1'b1; w4();
        dstb = 1'b0; w4();
        csn = 1'b1; rwb = 1'b1; w4();
    endtask

    task automatic moto_read(input logic [7:0] a, input logic x,
                             output logic [7:0] d, output logic oe_in, output logic oe_out);
        addr_phase(a, x);
        csn = 1'b0; rwb = 1'b1; w4();
        dstb = 1'b1; w4();
        oe_in = ad_oe_o; d = ad_o;
        dstb = 1'b0; w4();
        oe_out = ad_oe_o;
        csn = 1'b1; w4();
    endtask

    task automatic intel_write(input logic [7:0] a, input logic [7:0] d);
        addr_phase(a, 1'b0);
        csn = 1'b0; ad_in = d; w4();
        rwb = 1'b0; w4();
        rwb = 1'b1; w4();
        csn = 1'b1; w4();
    endtask

    task automatic intel_read(input logic [7:0] a,
                              output logic [7:0] d, output logic oe_in, output logic oe_out);
        addr_phase(a, 1'b0);
        csn = 1'b0; w4();
        dstb = 1'b0; w4();
        oe_in = ad_oe_o; d = ad_o;
        dstb = 1'b1; w4();
        oe_out = ad_oe_o;
        csn = 1'b1; w4();
    endtask

    task automatic t_reset_quiet();
        rst_n = 1'b0; mode = 1'b1;
        repeat (6) @(negedge clk);
        moto_write(8'h02, 1'b0, 8'h5A);
        check(wr_pulses == 0, "R9 no write in reset", wr_pulses, 0);
        check(ad_oe_o == 1'b0, "R9 oe low in reset", ad_oe_o, 0);
        do_reset(1'b1);
        check(ad_oe_o == 1'b0 && !acc_wr_o, "R9 idle after reset", ad_oe_o, 0);
    endtask

    task automatic t_moto_rw();
        logic [7:0] d; logic oi, oo;
        moto_write(8'h05, 1'b0, 8'hA5);
        check(m_ctrl[5] == 8'hA5, "R3 enable-mode write", m_ctrl[5], 8'hA5);
        moto_read(8'h05, 1'b0, d, oi, oo);
        check(oi == 1'b1, "R2 oe during read", oi, 1);
        check(d == 8'hA5, "R2 read data", d, 8'hA5);
        check(oo == 1'b0, "R11 oe released after read", oo, 0);
    endtask

    task automatic t_decode_base();
        moto_write(8'd14, 1'b0, 8'h11);
        check(m_store[0] == 8'h11, "R7 addr 14 to storage 0", m_store[0], 8'h11);
        moto_write(8'd255, 1'b0, 8'h22);
        check(m_store[241] == 8'h22, "R7 addr 255 to storage 241", m_store[241], 8'h22);
        moto_write(8'd13, 1'b0, 8'h33);
        check(m_ctrl[13] == 8'h33, "R7 addr 13 to ctrl 13", m_ctrl[13], 8'h33);
    endtask

    task automatic t_addr_latch();
        // address strobe falls with chip select high; bus then carries data 07
        moto_write(8'h03, 1'b0, 8'h07);
        check(m_ctrl[3] == 8'h07, "R1 address held from strobe fall", m_ctrl[3], 8'h07);
    endtask

    task automatic t_xbank();
        logic [7:0] d; logic oi, oo; int w0, r0;
        moto_write(8'h03, 1'b1, 8'h3C);
        check(m_xb[3] == 8'h3C, "R8 ext bank write", m_xb[3], 8'h3C);
        check(m_ctrl[3] == 8'h07, "R8 ctrl untouched by bank", m_ctrl[3], 8'h07);
        w0 = wr_pulses; r0 = rd_pulses;
        moto_write(8'd200, 1'b1, 8'h44);
        check(wr_pulses == w0, "R8 unmapped write no pulse", wr_pulses, w0);
        moto_read(8'd200, 1'b1, d, oi, oo);
        check(d == 8'hFF && oi, "R8 unmapped read FF", d, 8'hFF);
        check(rd_pulses == r0, "R8 unmapped read no pulse", rd_pulses, r0);
    endtask

    task automatic t_cs_abort();
        int w0;
        w0 = wr_pulses;
        addr_phase(8'h06, 1'b0);
        csn = 1'b0; rwb = 1'b0; ad_in = 8'h99; w4();
        dstb = 1'b1; w4();
        csn = 1'b1; w4();
        dstb = 1'b0; w4();
        rwb = 1'b1; w4();
        check(wr_pulses == w0, "R6 write withdrawn", wr_pulses, w0);
        addr_phase(8'h05, 1'b0);
        rwb = 1'b1; w4();
        dstb = 1'b1; w4();
        check(ad_oe_o == 1'b0, "R6 read without select", ad_oe_o, 0);
        dstb = 1'b0; w4();
    endtask

    task automatic t_no_reaccess();
        int w0;
        moto_write(8'h04, 1'b0, 8'h10);
        w0 = wr_pulses;
        csn = 1'b0; rwb = 1'b0; ad_in = 8'h20; w4();
        dstb = 1'b1; w4();
        dstb = 1'b0; w4();
        csn = 1'b1; rwb = 1'b1; w4();
        check(wr_pulses == w0, "R11 no second access", wr_pulses, w0);
        check(m_ctrl[4] == 8'h10, "R11 data kept", m_ctrl[4], 8'h10);
    endtask

    task automatic t_split_mode();
        logic [7:0] d; logic oi, oo;
        do_reset(1'b0);
        intel_write(8'h09, 8'h5C);
        check(m_ctrl[9] == 8'h5C, "R5 split-strobe write", m_ctrl[9], 8'h5C);
        intel_read(8'h09, d, oi, oo);
        check(oi == 1'b1 && d == 8'h5C, "R4 split-strobe read", d, 8'h5C);
        check(oo == 1'b0, "R4 oe drops at strobe rise", oo, 0);
    endtask

    task automatic t_mode_static();
        mode = 1'b1;
        w4();
        intel_write(8'h0A, 8'h6D);
        check(m_ctrl[10] == 8'h6D, "R10 mode pin ignored after reset", m_ctrl[10], 8'h6D);
    endtask

    task automatic t_pulse_width();
        check(wr_run_max == 1, "R12 write pulse width", wr_run_max, 1);
        check(rd_run_max == 1, "R12 read pulse width", rd_run_max, 1);
    endtask

    initial begin
        t_reset_quiet();
        t_moto_rw();
        t_decode_base();
        t_addr_latch();
        t_xbank();
        t_cs_abort();
        t_no_reaccess();
        t_split_mode();
        t_mode_static();
        t_pulse_width();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule